// File: doc/BRIEF.md
# Short-Code Direct-Sequence Symbol Correlator

This block turns a stream of received chips back into data symbols for three short spreading code families. Each chip arrives as a signed value on a valid strobe: a soft sample from the demodulator, or a hard decision presented as +1 or −1. For every symbol period the block keeps one running correlation per candidate codeword of the active family. After the last chip of the symbol it reports the candidate with the largest correlation and the value of that peak.

All candidates are derived from one root word per family by cyclic rotation and by inverting the chips at odd positions, so no per-symbol reference table is stored. A symbol-boundary sync input restarts accumulation and latches the family select. Symbols that follow the first are framed back to back by counting valid chips, without further syncs. Acquisition, timing and carrier recovery happen upstream.

Control is a two-state machine. S_IDLE waits for a sync and ignores chips. S_ACCUM accumulates chips. The transitions are:
- start: S_IDLE to S_ACCUM on a sync with a legal family code.
- abort: S_ACCUM to S_IDLE on a sync with the reserved family code.
- restart: S_ACCUM to S_ACCUM on a sync with a legal code; the count and sums are cleared.
- wrap: S_ACCUM to S_ACCUM on the last chip of a symbol; the result is issued and the count returns to zero.

Top module: `dsd_correlator`

## Requirements
- R1: After reset `sym_valid_o`, `sym_o` and `metric_o` are 0 and the block is idle; chips presented before the first sync produce no result.
- R2: Family code 0 uses 16 chips and 16 candidates from root 0x3AFC, chip 0 being the root's most significant bit. Candidate k, chip i equals root chip ((i − 2·k[2:0]) mod 16). When k[3] is 1, the chips at odd i are inverted.
- R3: Family code 1 uses 8 chips and 16 candidates from root 0xB2 (chip 0 = bit 7). Candidate k, chip i equals root chip ((i − k[2:0]) mod 8). The chips at odd i are inverted when k[3] is 1.
- R4: Family code 2 uses 8 chips and 8 candidates from root 0x45 (chip 0 = bit 7). Candidate k, chip i equals root chip ((i − 2·k[1:0]) mod 8). The chips at odd i are inverted when k[2] is 1. `sym_o[3]` is always 0 in this family.
- R5: The correlation of a candidate is the sum over the symbol's chips of +c where the reference chip is 1 and −c where it is 0, c being the chip input taken as two's complement. `metric_o` carries this sum for the chosen candidate.
- R6: `sym_o` is the index of the largest correlation, and the lowest index wins a tie. Bit 0 of `sym_o` is the first data bit of the symbol.
- R7: `sym_valid_o` is a one-cycle pulse in the cycle after the clock edge that accepts the last valid chip of a symbol. The next valid chip then starts a new symbol without a sync.
- R8: A sync clears the count and all sums. A chip presented together with the sync becomes chip 0 of the new symbol.
- R9: The family code is sampled only with a sync; changing it between syncs has no effect on the symbol in progress.
- R10: A sync carrying the reserved family code 3 puts the block in S_IDLE. After that, no result is issued until a sync with a legal code.
- R11: Cycles with `chip_valid_i` low neither advance the chip count nor change any sum, whatever value `chip_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_i | input | CHIP_W | Signed chip value |
| chip_valid_i | input | 1 | Chip strobe |
| sync_i | input | 1 | Symbol-boundary sync; restarts accumulation |
| mode_i | input | 2 | Code family: 0 16-chip, 1 8-chip 4-bit, 2 8-chip 3-bit, 3 reserved |
| sym_o | output | 4 | Decided symbol index |
| metric_o | output | CHIP_W+5 | Signed peak correlation |
| sym_valid_o | output | 1 | Result strobe |

## Verification
The assertions check these properties on every cycle:
- the result strobe never lasts longer than one cycle;
- the idle state never produces a result;
- the chip count stays below the active code length;
- a sync that carries no chip leaves every sum at zero;
- the reported peak stays within the bound set by the chip width;
- the 3-bit family never reports an index above 7.

The bench shows what only concrete stimulus can reveal: that each candidate of each family decodes to its own index with the full peak, that soft and noisy chips give the arithmetic argmax with the right tie rule, and that gaps, mid-symbol family changes, early restarts and the reserved code are handled as required.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    localparam int NCAND = 16;
    localparam int NCHIP = 16;
    localparam int CNT_W = $clog2(NCHIP);
    localparam int SYM_W = $clog2(NCAND);

    typedef enum logic [1:0] {
        MODE_L16 = 2'd0,
        MODE_L8Q = 2'd1,
        MODE_L8T = 2'd2,
        MODE_BAD = 2'd3
    } mode_e;

    function automatic int code_len(mode_e m);
        return (m == MODE_L16) ? 16 : 8;
    endfunction

    function automatic int code_cands(mode_e m);
        case (m)
            MODE_L16, MODE_L8Q: return 16;
            MODE_L8T:           return 8;
            default:            return 0;
        endcase
    endfunction

    // Reference chip i of candidate k: rotate the root right, then
    // optionally flip the odd-position chips.
    function automatic logic ref_chip(mode_e m, int k, int i);
        logic [15:0] root;
        int          len;
        int          rot;
        logic        inv;
        int          src;
        case (m)
            MODE_L16: begin root = 16'h3AFC; len = 16; rot = 2 * (k % 8); inv = ((k / 8) % 2) == 1; end
            MODE_L8Q: begin root = 16'h00B2; len = 8;  rot = k % 8;       inv = ((k / 8) % 2) == 1; end
            MODE_L8T: begin root = 16'h0045; len = 8;  rot = 2 * (k % 4); inv = ((k / 4) % 2) == 1; end
            default:  begin root = 16'h0000; len = 16; rot = 0;           inv = 1'b0;               end
        endcase
        if (i >= len) return 1'b0;
        src = (i + len - rot) % len;
        return root[len - 1 - src] ^ (inv && ((i % 2) == 1));
    endfunction

endpackage

// File: rtl/dsd_refgen.sv
module dsd_refgen
    import dsd_pkg::*;
(
    input  mode_e                        mode_i,
    output logic [NCAND-1:0][NCHIP-1:0]  ref_o,
    output logic [NCAND-1:0]             legal_o
);

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        for (genvar i = 0; i < NCHIP; i++) begin : g_chip
            assign ref_o[k][i] = ref_chip(mode_i, k, i);
        end
        assign legal_o[k] = (k < code_cands(mode_i));
    end

endmodule

// File: rtl/dsd_acc_bank.sv
module dsd_acc_bank
    import dsd_pkg::*;
#(
    parameter int CHIP_W = 6,
    parameter int ACC_W  = CHIP_W + 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_i,
    input  logic                             take_i,
    input  logic                             last_i,
    input  logic signed [CHIP_W-1:0]         chip_i,
    input  logic [CNT_W-1:0]                 idx_i,
    input  logic [NCAND-1:0][NCHIP-1:0]      ref_i,
    output logic signed [ACC_W-1:0]          acc_nxt_o [NCAND]
);

    logic signed [ACC_W-1:0] chip_ext;
    logic signed [ACC_W-1:0] acc_q [NCAND];

    assign chip_ext = {{(ACC_W-CHIP_W){chip_i[CHIP_W-1]}}, chip_i};

    for (genvar k = 0; k < NCAND; k++) begin : g_acc
        logic signed [ACC_W-1:0] base;
        logic signed [ACC_W-1:0] contrib;

        always_comb begin
            base         = clear_i ? '0 : acc_q[k];
            contrib      = ref_i[k][idx_i] ? chip_ext : -chip_ext;
            acc_nxt_o[k] = take_i ? base + contrib : base;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc_q[k] <= '0;
            else if (last_i) acc_q[k] <= '0;
            else             acc_q[k] <= acc_nxt_o[k];
        end

        // A sync carrying no chip leaves the sum empty (R8).
        p_sync_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clear_i && !take_i) |=> (acc_q[k] == '0));
    end

endmodule

// File: rtl/dsd_argmax.sv
module dsd_argmax
    import dsd_pkg::*;
#(
    parameter int ACC_W = 11
) (
    input  logic signed [ACC_W-1:0] acc_i [NCAND],
    input  logic [NCAND-1:0]        legal_i,
    output logic [SYM_W-1:0]        best_idx_o,
    output logic signed [ACC_W-1:0] best_val_o
);

    always_comb begin
        logic found;
        found      = 1'b0;
        best_idx_o = '0;
        best_val_o = '0;
        for (int k = 0; k < NCAND; k++) begin
            // Strictly greater: on equal sums the earlier index is kept.
            if (legal_i[k] && (!found || acc_i[k] > best_val_o)) begin
                found      = 1'b1;
                best_idx_o = SYM_W'(k);
                best_val_o = acc_i[k];
            end
        end
    end

endmodule

// File: rtl/dsd_correlator.sv
module dsd_correlator
    import dsd_pkg::*;
#(
    parameter int CHIP_W = 6,
    localparam int ACC_W = CHIP_W + 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [CHIP_W-1:0] chip_i,
    input  logic                     chip_valid_i,
    input  logic                     sync_i,
    input  logic [1:0]               mode_i,
    output logic [SYM_W-1:0]         sym_o,
    output logic signed [ACC_W-1:0]  metric_o,
    output logic                     sym_valid_o
);

    localparam int MAX_MAG = NCHIP * (2 ** (CHIP_W - 1));

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ACCUM = 1'b1
    } state_e;

    state_e           state_q, state_d;
    mode_e            mode_q, eff_mode;
    logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt;
    logic             legal_sync, run, take, last;

    logic [NCAND-1:0][NCHIP-1:0] refs;
    logic [NCAND-1:0]            legal;
    logic signed [ACC_W-1:0]     acc_nxt [NCAND];
    logic [SYM_W-1:0]            best_idx;
    logic signed [ACC_W-1:0]     best_val;

    // Family and framing for the chip in this cycle.
    always_comb begin
        eff_mode   = sync_i ? mode_e'(mode_i) : mode_q;
        legal_sync = sync_i && (mode_e'(mode_i) != MODE_BAD);
        run        = sync_i ? legal_sync : (state_q == S_ACCUM);
        take       = chip_valid_i && run;
        base_cnt   = sync_i ? '0 : cnt_q;
        last       = take && (int'(base_cnt) == code_len(eff_mode) - 1);
    end

    // Next state and count.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (legal_sync) state_d = S_ACCUM;                    // start
            S_ACCUM: if (sync_i && !legal_sync) state_d = S_IDLE;          // abort
        endcase
        if (!run)      cnt_d = '0;
        else if (last) cnt_d = '0;                                         // wrap
        else if (take) cnt_d = base_cnt + 1'b1;
        else           cnt_d = base_cnt;                                   // restart clears
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            mode_q  <= MODE_L16;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (sync_i) mode_q <= mode_e'(mode_i);
        end
    end

    dsd_refgen u_refgen (
        .mode_i  (eff_mode),
        .ref_o   (refs),
        .legal_o (legal)
    );

    dsd_acc_bank #(.CHIP_W(CHIP_W), .ACC_W(ACC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (sync_i),
        .take_i    (take),
        .last_i    (last),
        .chip_i    (chip_i),
        .idx_i     (base_cnt),
        .ref_i     (refs),
        .acc_nxt_o (acc_nxt)
    );

    dsd_argmax #(.ACC_W(ACC_W)) u_argmax (
        .acc_i      (acc_nxt),
        .legal_i    (legal),
        .best_idx_o (best_idx),
        .best_val_o (best_val)
    );

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_valid_o <= 1'b0;
            sym_o       <= '0;
            metric_o    <= '0;
        end else begin
            sym_valid_o <= last;
            if (last) begin
                sym_o    <= best_idx;
                metric_o <= best_val;
            end
        end
    end

    p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |=> !sym_valid_o);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !sym_valid_o);

    p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (cnt_q == '0));

    p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCUM) |-> (int'(cnt_q) < code_len(mode_q)));

    p_tri_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_o && mode_q == MODE_L8T) |-> !sym_o[SYM_W-1]);

    p_metric_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> (metric_o <= MAX_MAG && metric_o >= -MAX_MAG));

endmodule

// File: tb/test_dsd_correlator.sv
module test_dsd_correlator;

    localparam int CW = 6;
    localparam int AW = CW + 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [CW-1:0] chip;
    logic                 cv, sy;
    logic [1:0]           md;
    logic [3:0]           sym;
    logic signed [AW-1:0] met;
    logic                 sv;

    int checks = 0;
    int fails = 0;
    int n_pulse = 0;
    int seed = 7;
    int exp_sym, exp_met;
    int buffer [16];

    always #4 clk = ~clk;

    dsd_correlator #(.CHIP_W(CW)) i_dsd_correlator (
        .clk(clk), .rst_n(rst_n), .chip_i(chip), .chip_valid_i(cv),
        .sync_i(sy), .mode_i(md), .sym_o(sym), .metric_o(met), .sym_valid_o(sv)
    );

    always @(posedge clk) begin
        #1;
        if (rst_n && sv) n_pulse++;
    end

    function automatic int len_of(int m);
        return (m == 0) ? 16 : 8;
    endfunction

    function automatic int ncand(int m);
        return (m == 2) ? 8 : 16;
    endfunction

    function automatic bit refb(int m, int k, int i);
        int r, n, sh, src;
        bit flip;
        if (m == 0)      begin r = 'h3AFC; n = 16; sh = 2 * (k % 8); flip = (k / 8) % 2 == 1; end
        else if (m == 1) begin r = 'hB2;   n = 8;  sh = k % 8;       flip = (k / 8) % 2 == 1; end
        else             begin r = 'h45;   n = 8;  sh = 2 * (k % 4); flip = (k / 4) % 2 == 1; end
        src = (i - sh + n) % n;
        return bit'(((r >> (n - 1 - src)) & 1) ^ ((flip && i % 2 == 1) ? 1 : 0));
    endfunction

    function automatic int rnd(int span);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 32767) % span;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic compute_exp(int m);
        int c;
        exp_sym = 0;
        exp_met = 0;
        for (int k = 0; k < ncand(m); k++) begin
            c = 0;
            for (int i = 0; i < len_of(m); i++) c += refb(m, k, i) ? buffer[i] : -buffer[i];
            if (k == 0 || c > exp_met) begin exp_sym = k; exp_met = c; end
        end
    endtask

    task automatic fill_hard(int m, int k, int amp);
        for (int i = 0; i < 16; i++) buffer[i] = refb(m, k, i) ? amp : -amp;
    endtask

    // Drive one symbol. gap: idle cycles with junk before every third chip.
    // chg: family code driven from chip 3 on (without sync).
    task automatic send_sym(int m, bit with_sync, int gap, int chg);
        for (int i = 0; i < len_of(m); i++) begin
            if (gap > 0 && i % 3 == 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    cv = 1'b0; sy = 1'b0; chip = 6'sd31;
                end
            end
            @(negedge clk);
            chip = CW'(buffer[i]);
            cv   = 1'b1;
            sy   = with_sync && (i == 0);
            md   = (chg >= 0 && i >= 3) ? 2'(chg) : 2'(m);
        end
        @(negedge clk);
        cv = 1'b0; sy = 1'b0;
    endtask

    task automatic expect_result(string req, int es, int em);
        check(sv == 1'b1, req, "valid", int'(sv), 1);
        check(int'(sym) == es, req, "symbol", int'(sym), es);
        check(int'(met) == em, req, "metric", int'(met), em);
        @(negedge clk);
        check(sv == 1'b0, "R7", "pulse end", int'(sv), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int p0;
        chip = '0; cv = 1'b0; sy = 1'b0; md = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(sv == 1'b0, "R1", "valid after reset", int'(sv), 0);
        check(sym == 4'd0, "R1", "symbol after reset", int'(sym), 0);
        check(met == '0, "R1", "metric after reset", int'(met), 0);

        // R1: chips before any sync give nothing
        p0 = n_pulse;
        fill_hard(0, 0, 1);
        send_sym(0, 1'b0, 0, -1);
        send_sym(0, 1'b0, 0, -1);
        repeat (2) @(negedge clk);
        check(n_pulse == p0, "R1", "pulses without sync", n_pulse - p0, 0);

        // R2: every 16-chip candidate decodes to itself with peak 16
        for (int k = 0; k < 16; k++) begin
            fill_hard(0, k, 1);
            send_sym(0, 1'b1, 0, -1);
            expect_result("R2", k, 16);
        end

        // R3 with R7: 8-chip 4-bit family, back to back after one sync
        for (int k = 0; k < 16; k++) begin
            fill_hard(1, k, 1);
            send_sym(1, k == 0, 0, -1);
            expect_result("R3", k, 8);
        end

        // R4: 8-chip 3-bit family
        for (int k = 0; k < 8; k++) begin
            fill_hard(2, k, 1);
            send_sym(2, 1'b1, 0, -1);
            expect_result("R4", k, 8);
        end

        // R5 and R6: soft chips, scaled codewords plus noise, and pure noise
        for (int n = 0; n < 30; n++) begin
            int m, k;
            m = n % 3;
            k = rnd(ncand(m));
            for (int i = 0; i < 16; i++)
                buffer[i] = (n % 5 == 4) ? rnd(15) - 7 : ((refb(m, k, i) ? 3 : -3) + rnd(8) - 4);
            compute_exp(m);
            send_sym(m, 1'b1, 0, -1);
            expect_result("R5", exp_sym, exp_met);
        end

        // R6: all sums equal, lowest index wins
        for (int i = 0; i < 16; i++) buffer[i] = 0;
        send_sym(0, 1'b1, 0, -1);
        expect_result("R6", 0, 0);
        send_sym(2, 1'b1, 0, -1);
        expect_result("R6", 0, 0);

        // R11: invalid cycles carrying junk are ignored
        fill_hard(1, 5, 2);
        send_sym(1, 1'b1, 2, -1);
        expect_result("R11", 5, 16);

        // R9: family code changed mid-symbol has no effect
        fill_hard(0, 11, 1);
        send_sym(0, 1'b1, 0, 2);
        expect_result("R9", 11, 16);

        // R8: partial junk symbol, then restart with a sync
        p0 = n_pulse;
        for (int i = 0; i < 16; i++) buffer[i] = 7;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chip = 6'sd7; cv = 1'b1; sy = (i == 0); md = 2'd0;
        end
        fill_hard(0, 6, 1);
        send_sym(0, 1'b1, 0, -1);
        check(n_pulse == p0 + 1, "R8", "pulses around restart", n_pulse - p0, 1);
        expect_result("R8", 6, 16);

        // R10: reserved family code idles the block
        p0 = n_pulse;
        fill_hard(0, 3, 1);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chip = CW'(buffer[i]); cv = 1'b1; sy = (i == 0); md = 2'd3;
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chip = CW'(buffer[i]); cv = 1'b1; sy = 1'b0; md = 2'd0;
        end
        @(negedge clk);
        cv = 1'b0;
        repeat (2) @(negedge clk);
        check(n_pulse == p0, "R10", "pulses after reserved code", n_pulse - p0, 0);
        fill_hard(0, 9, 1);
        send_sym(0, 1'b1, 0, -1);
        expect_result("R10", 9, 16);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule